// File: doc/BRIEF.md
# Accumulator and Extension Shift and Normalize Unit

This unit carries out the shift family of a 16-bit processor on its accumulator and its 16-bit extension register, which together form a 32-bit pair. A start pulse captures the operands, a direction bit, the two variant bits of the instruction (instruction bits 7 and 6), the already selected 6-bit shift count, a flag saying whether an index tag is in use, and the current index register value. The unit then shifts one bit per clock and reports completion with a one-cycle done pulse. At that point it presents the new accumulator, extension and carry, and where it applies, an index writeback value or an invalid-operation flag.

Left shifts move either the accumulator alone or the whole pair. The two normalize variants, when a tag is in use, stop as soon as the accumulator sign bit is set. They return the count that was not used to the low bits of the index register, and the carry flag says whether the unit stopped before the count ran out. Right shifts are logical on the accumulator, arithmetic on the pair, or a rotate of the pair. One code point is invalid.

Top module: `shf_norm_unit`

## Requirements
- R1: After reset, busy, done, idx_wr and invalid are 0, and acc_out, ext_out, carry_out and idx_val are all zero.
- R2: A count of zero leaves accumulator, extension and carry equal to the inputs for every direction and variant, raises neither idx_wr nor invalid, and completes with done one cycle after the start edge.
- R3: Left shift with variant 00 (dir_right=0) shifts only the accumulator, fills bit 0 with zero, and leaves the extension unchanged. Carry takes the last bit shifted out of accumulator bit 15.
- R4: Left shift with variant 10 shifts the 32-bit pair {acc,ext}. Extension bit 15 enters accumulator bit 0, and carry takes the last bit shifted out of accumulator bit 15.
- R5: With tag_nz=1 and a nonzero count, variant 01 (accumulator only) and variant 11 (pair) shift only while accumulator bit 15 is 0 and count remains. At done, carry is 1 exactly when count remains, and idx_wr pulses with idx_val = {idx_in[15:8], 2'b00, remaining count[5:0]}.
- R6: With tag_nz=0, left variant 01 behaves exactly as variant 00, left variant 11 behaves exactly as variant 10, and neither raises idx_wr.
- R7: Right shift (dir_right=1) with variant 00 shifts the accumulator right with zero fill, so a count of 16 or more gives zero. Extension and carry are unchanged.
- R8: Right variant 10 shifts the pair arithmetically, keeping accumulator bit 15 and moving accumulator bit 0 into extension bit 15. Carry is unchanged.
- R9: Right variant 11 rotates the pair right, with extension bit 0 entering accumulator bit 15 and accumulator bit 0 entering extension bit 15. Carry is unchanged.
- R10: Right variant 01 with a nonzero count raises invalid together with done and leaves accumulator, extension and carry equal to the inputs, without raising idx_wr.
- R11: done is a one-cycle pulse exactly S+1 clock edges after the start edge, where S is the number of bit steps taken. busy is high from the edge after start until done rises, and the results hold until the next accepted start.
- R12: A start pulse that arrives while busy is high is ignored, and the running operation completes with its own operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begins an operation when idle |
| dir_right | input | 1 | 0 = left family, 1 = right family |
| variant | input | 2 | Instruction bits 7..6 selecting the variant |
| count | input | 6 | Shift count already taken from displacement or index |
| tag_nz | input | 1 | An index tag is in use |
| idx_in | input | 16 | Current index register value |
| acc_in | input | 16 | Accumulator operand |
| ext_in | input | 16 | Extension operand |
| carry_in | input | 1 | Current carry flag |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| acc_out | output | 16 | Resulting accumulator |
| ext_out | output | 16 | Resulting extension |
| carry_out | output | 1 | Resulting carry flag |
| idx_wr | output | 1 | Index writeback strobe, coincident with done |
| idx_val | output | 16 | Index writeback value |
| invalid | output | 1 | Invalid-operation flag, coincident with done |

## Verification
The bench builds the unit with its default widths: a 16-bit data path and a 6-bit count. Every count from 0 to 63 can therefore be applied, including counts of 16 and above, where the accumulator-only and logical right shifts run past the register width and must produce all zeros. Those widths also let normalize runs stop at any step, from zero steps (sign already set) up to the full count, so both carry outcomes and every remaining-count value are within reach.

// File: rtl/shf_pkg.sv
package shf_pkg;
  typedef enum logic [2:0] {
    K_SL_ACC,
    K_SL_PAIR,
    K_SR_LOG,
    K_SR_ARITH,
    K_SR_ROT
  } step_kind_e;

  typedef enum logic {
    S_IDLE,
    S_RUN
  } shf_state_e;
endpackage

// File: rtl/shf_decode.sv
module shf_decode
  import shf_pkg::*;
(
  input  logic       dir_right,
  input  logic [1:0] variant,
  input  logic       tag_nz,
  output step_kind_e kind,
  output logic       norm,
  output logic       bad
);
  always_comb begin
    kind = K_SL_ACC;
    norm = 1'b0;
    bad  = 1'b0;
    if (!dir_right) begin
      kind = variant[1] ? K_SL_PAIR : K_SL_ACC;
      norm = variant[0] & tag_nz;
    end else begin
      case (variant)
        2'b00:   kind = K_SR_LOG;
        2'b10:   kind = K_SR_ARITH;
        2'b11:   kind = K_SR_ROT;
        default: begin
          kind = K_SR_LOG;
          bad  = 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/shf_step.sv
module shf_step
  import shf_pkg::*;
#(
  parameter int W = 16
) (
  input  step_kind_e     kind,
  input  logic [W-1:0]   acc,
  input  logic [W-1:0]   ext,
  output logic [W-1:0]   acc_nx,
  output logic [W-1:0]   ext_nx,
  output logic           msb_out
);
  assign msb_out = acc[W-1];

  always_comb begin
    acc_nx = acc;
    ext_nx = ext;
    case (kind)
      K_SL_ACC:   acc_nx = {acc[W-2:0], 1'b0};
      K_SL_PAIR: begin
        acc_nx = {acc[W-2:0], ext[W-1]};
        ext_nx = {ext[W-2:0], 1'b0};
      end
      K_SR_LOG:   acc_nx = {1'b0, acc[W-1:1]};
      K_SR_ARITH: begin
        acc_nx = {acc[W-1], acc[W-1:1]};
        ext_nx = {acc[0], ext[W-1:1]};
      end
      K_SR_ROT: begin
        acc_nx = {ext[0], acc[W-1:1]};
        ext_nx = {acc[0], ext[W-1:1]};
      end
      default: begin
        acc_nx = acc;
        ext_nx = ext;
      end
    endcase
  end
endmodule

// File: rtl/shf_norm_unit.sv
module shf_norm_unit
  import shf_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              dir_right,
  input  logic [1:0]        variant,
  input  logic [CNT_W-1:0]  count,
  input  logic              tag_nz,
  input  logic [DATA_W-1:0] idx_in,
  input  logic [DATA_W-1:0] acc_in,
  input  logic [DATA_W-1:0] ext_in,
  input  logic              carry_in,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] acc_out,
  output logic [DATA_W-1:0] ext_out,
  output logic              carry_out,
  output logic              idx_wr,
  output logic [DATA_W-1:0] idx_val,
  output logic              invalid
);
  localparam int KEEP_LO = 8;
  localparam int HI_W    = DATA_W - KEEP_LO;
  localparam int PAD_W   = KEEP_LO - CNT_W;

  // reset: asserted at once, released through two flops
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  step_kind_e        dec_kind;
  logic              dec_norm, dec_bad;
  logic              cnt_zero;

  shf_decode u_dec (
    .dir_right (dir_right),
    .variant   (variant),
    .tag_nz    (tag_nz),
    .kind      (dec_kind),
    .norm      (dec_norm),
    .bad       (dec_bad)
  );

  assign cnt_zero = (count == '0);

  shf_state_e        st_q, st_n;
  step_kind_e        kind_q, kind_n;
  logic              norm_q, norm_n, bad_q, bad_n;
  logic [CNT_W-1:0]  rem_q, rem_n;
  logic [HI_W-1:0]   hi_q, hi_n;
  logic [DATA_W-1:0] acc_q, acc_n, ext_q, ext_n, idxv_q, idxv_n;
  logic              c_q, c_n;
  logic              done_q, done_n, wr_q, wr_n, inv_q, inv_n;
  logic [DATA_W-1:0] stp_acc, stp_ext;
  logic              stp_msb, stop, en;

  shf_step #(.W(DATA_W)) u_step (
    .kind    (kind_q),
    .acc     (acc_q),
    .ext     (ext_q),
    .acc_nx  (stp_acc),
    .ext_nx  (stp_ext),
    .msb_out (stp_msb)
  );

  assign stop = (rem_q == '0) || (norm_q && acc_q[DATA_W-1]);
  assign en   = (st_q == S_RUN) || start || done_q;

  always_comb begin
    st_n   = st_q;
    kind_n = kind_q;
    norm_n = norm_q;
    bad_n  = bad_q;
    rem_n  = rem_q;
    hi_n   = hi_q;
    acc_n  = acc_q;
    ext_n  = ext_q;
    c_n    = c_q;
    idxv_n = idxv_q;
    done_n = 1'b0;
    wr_n   = 1'b0;
    inv_n  = 1'b0;
    case (st_q)
      S_IDLE: begin
        if (start) begin
          st_n   = S_RUN;
          kind_n = dec_kind;
          norm_n = dec_norm & ~cnt_zero;
          bad_n  = dec_bad & ~cnt_zero;
          rem_n  = dec_bad ? '0 : count;
          hi_n   = idx_in[DATA_W-1:KEEP_LO];
          acc_n  = acc_in;
          ext_n  = ext_in;
          c_n    = carry_in;
        end
      end
      default: begin
        if (!stop) begin
          acc_n = stp_acc;
          ext_n = stp_ext;
          rem_n = rem_q - 1'b1;
          if (!norm_q && (kind_q == K_SL_ACC || kind_q == K_SL_PAIR))
            c_n = stp_msb;
        end else begin
          st_n   = S_IDLE;
          done_n = 1'b1;
          inv_n  = bad_q;
          if (norm_q) begin
            wr_n   = 1'b1;
            c_n    = (rem_q != '0);
            idxv_n = {hi_q, {PAD_W{1'b0}}, rem_q};
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      st_q   <= S_IDLE;
      kind_q <= K_SL_ACC;
      norm_q <= 1'b0;
      bad_q  <= 1'b0;
      rem_q  <= '0;
      hi_q   <= '0;
      acc_q  <= '0;
      ext_q  <= '0;
      c_q    <= 1'b0;
      idxv_q <= '0;
      done_q <= 1'b0;
      wr_q   <= 1'b0;
      inv_q  <= 1'b0;
    end else if (en) begin
      st_q   <= st_n;
      kind_q <= kind_n;
      norm_q <= norm_n;
      bad_q  <= bad_n;
      rem_q  <= rem_n;
      hi_q   <= hi_n;
      acc_q  <= acc_n;
      ext_q  <= ext_n;
      c_q    <= c_n;
      idxv_q <= idxv_n;
      done_q <= done_n;
      wr_q   <= wr_n;
      inv_q  <= inv_n;
    end
  end

  assign busy      = (st_q == S_RUN);
  assign done      = done_q;
  assign acc_out   = acc_q;
  assign ext_out   = ext_q;
  assign carry_out = c_q;
  assign idx_wr    = wr_q;
  assign idx_val   = idxv_q;
  assign invalid   = inv_q;
endmodule

// File: rtl/shf_norm_unit_chk.sv
module shf_norm_unit_chk #(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              carry_out,
  input logic              idx_wr,
  input logic [DATA_W-1:0] idx_val,
  input logic [DATA_W-1:0] acc_out,
  input logic              invalid
);
  a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r11_busy_ends_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  a_r10_invalid_alone: assert property (@(posedge clk) disable iff (!rst_n)
    invalid |-> (done && !idx_wr));

  a_r5_wr_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    idx_wr |-> done);

  a_r5_carry_matches_rem: assert property (@(posedge clk) disable iff (!rst_n)
    idx_wr |-> (carry_out == (idx_val[CNT_W-1:0] != '0)));

  a_r5_early_stop_sign: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_wr && carry_out) |-> acc_out[DATA_W-1]);
endmodule

bind shf_norm_unit shf_norm_unit_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .done      (done),
  .carry_out (carry_out),
  .idx_wr    (idx_wr),
  .idx_val   (idx_val),
  .acc_out   (acc_out),
  .invalid   (invalid)
);

// File: tb/shf_norm_unit_bench.sv
`timescale 1ns/1ps
module shf_norm_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start, dir_right, tag_nz, carry_in;
  logic [1:0]  variant;
  logic [5:0]  count;
  logic [15:0] idx_in, acc_in, ext_in;
  logic        busy, done, carry_out, idx_wr, invalid;
  logic [15:0] acc_out, ext_out, idx_val;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  shf_norm_unit u_shf_norm_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .dir_right(dir_right),
    .variant(variant), .count(count), .tag_nz(tag_nz), .idx_in(idx_in),
    .acc_in(acc_in), .ext_in(ext_in), .carry_in(carry_in), .busy(busy),
    .done(done), .acc_out(acc_out), .ext_out(ext_out), .carry_out(carry_out),
    .idx_wr(idx_wr), .idx_val(idx_val), .invalid(invalid)
  );

  typedef struct packed {
    logic        d;
    logic [1:0]  v;
    logic [5:0]  n;
    logic        t;
    logic [15:0] ix;
    logic [15:0] a;
    logic [15:0] e;
    logic        c;
    logic [15:0] xa;
    logic [15:0] xe;
    logic        xc;
  } vec_t;

  localparam vec_t TBL [8] = '{
    '{1'b0, 2'b00, 6'd4,  1'b0, 16'h0000, 16'h1234, 16'h5678, 1'b0, 16'h2340, 16'h5678, 1'b1},
    '{1'b1, 2'b00, 6'd20, 1'b0, 16'h0000, 16'hFFFF, 16'h0F0F, 1'b1, 16'h0000, 16'h0F0F, 1'b1},
    '{1'b1, 2'b10, 6'd4,  1'b0, 16'h0000, 16'h8001, 16'h0000, 1'b0, 16'hF800, 16'h1000, 1'b0},
    '{1'b1, 2'b11, 6'd8,  1'b0, 16'h0000, 16'h1234, 16'h5678, 1'b0, 16'h7812, 16'h3456, 1'b0},
    '{1'b0, 2'b11, 6'd5,  1'b1, 16'hAB05, 16'h0010, 16'h8000, 1'b1, 16'h0210, 16'h0000, 1'b0},
    '{1'b0, 2'b01, 6'd10, 1'b1, 16'h120A, 16'h0100, 16'h4444, 1'b0, 16'h8000, 16'h4444, 1'b1},
    '{1'b1, 2'b01, 6'd3,  1'b0, 16'h0000, 16'hBEEF, 16'hCAFE, 1'b1, 16'hBEEF, 16'hCAFE, 1'b1},
    '{1'b0, 2'b00, 6'd0,  1'b0, 16'h0000, 16'h8421, 16'h1111, 1'b1, 16'h8421, 16'h1111, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic void ref_op(
    input logic d, input logic [1:0] v, input logic [5:0] n, input logic t,
    input logic [15:0] ix, input logic [15:0] a, input logic [15:0] e, input logic c,
    output logic [15:0] ra, output logic [15:0] re, output logic rc,
    output logic rw, output logic [15:0] ri, output logic rinv, output int steps);
    logic [31:0] p;
    int k;
    ra = a; re = e; rc = c; rw = 1'b0; ri = 16'h0; rinv = 1'b0; steps = 0;
    if (n == 0) return;
    if (!d) begin
      if (v[0] && t) begin
        k = n;
        while (k > 0 && !ra[15]) begin
          if (v[1]) begin p = {ra, re} << 1; ra = p[31:16]; re = p[15:0]; end
          else ra = ra << 1;
          k--; steps++;
        end
        rc = (k != 0); rw = 1'b1; ri = {ix[15:8], 2'b00, 6'(k)};
      end else begin
        for (int i = 0; i < n; i++) begin
          rc = ra[15];
          if (v[1]) begin p = {ra, re} << 1; ra = p[31:16]; re = p[15:0]; end
          else ra = ra << 1;
        end
        steps = n;
      end
    end else begin
      case (v)
        2'b00: begin ra = (n >= 16) ? 16'h0 : (a >> n); steps = n; end
        2'b01: rinv = 1'b1;
        2'b10: begin p = 32'($signed({a, e}) >>> n); ra = p[31:16]; re = p[15:0]; steps = n; end
        default: begin
          p = {a, e};
          for (int i = 0; i < n; i++) p = {p[0], p[31:1]};
          ra = p[31:16]; re = p[15:0]; steps = n;
        end
      endcase
    end
  endfunction

  // drive one operation at a falling edge, wait for done; returns falling edges waited
  task automatic run_op(input logic d, input logic [1:0] v, input logic [5:0] n,
                        input logic t, input logic [15:0] ix, input logic [15:0] a,
                        input logic [15:0] e, input logic c, output int waited);
    dir_right = d; variant = v; count = n; tag_nz = t; idx_in = ix;
    acc_in = a; ext_in = e; carry_in = c; start = 1'b1;
    waited = 0;
    @(negedge clk);
    start = 1'b0;
    waited = 1;
    while (!done && waited < 200) begin
      @(negedge clk);
      waited++;
    end
    if (!done) chk("R11 watchdog done", 32'd0, 32'd1);
  endtask

  task automatic full_check(input string req, input logic d, input logic [1:0] v,
                            input logic [5:0] n, input logic t, input logic [15:0] ix,
                            input logic [15:0] a, input logic [15:0] e, input logic c);
    logic [15:0] ra, re, ri;
    logic rc, rw, rinv;
    int steps, waited;
    ref_op(d, v, n, t, ix, a, e, c, ra, re, rc, rw, ri, rinv, steps);
    run_op(d, v, n, t, ix, a, e, c, waited);
    chk({req, " acc"}, 32'(acc_out), 32'(ra));
    chk({req, " ext"}, 32'(ext_out), 32'(re));
    chk({req, " carry"}, 32'(carry_out), 32'(rc));
    chk({req, " idx_wr"}, 32'(idx_wr), 32'(rw));
    if (rw) chk({req, " idx_val"}, 32'(idx_val), 32'(ri));
    chk({req, " invalid"}, 32'(invalid), 32'(rinv));
    chk("R11 latency", 32'(waited), 32'(steps + 2));
    @(negedge clk);
    chk("R11 done single pulse", 32'(done), 32'd0);
  endtask

  bit finished = 1'b0;
  initial begin
    #700000;
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [15:0] ra, re, ri;
    logic rc, rw, rinv;
    int steps, waited;
    start = 0; dir_right = 0; variant = 0; count = 0; tag_nz = 0;
    idx_in = 0; acc_in = 0; ext_in = 0; carry_in = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1 busy", 32'(busy), 0);
    chk("R1 done", 32'(done), 0);
    chk("R1 outputs", {acc_out, ext_out}, 32'h0);
    chk("R1 flags", {29'd0, carry_out, idx_wr, invalid}, 32'h0);
    chk("R1 idx_val", 32'(idx_val), 0);

    // table of hand-worked vectors (R3 R7 R8 R9 R5 R10 R2)
    foreach (TBL[i]) begin
      run_op(TBL[i].d, TBL[i].v, TBL[i].n, TBL[i].t, TBL[i].ix,
             TBL[i].a, TBL[i].e, TBL[i].c, waited);
      chk("R3-table acc", 32'(acc_out), 32'(TBL[i].xa));
      chk("R4-table ext", 32'(ext_out), 32'(TBL[i].xe));
      chk("R5-table carry", 32'(carry_out), 32'(TBL[i].xc));
      @(negedge clk);
    end
    // R5 index writeback for the two normalize rows
    run_op(1'b0, 2'b11, 6'd5, 1'b1, 16'hAB05, 16'h0010, 16'h8000, 1'b1, waited);
    chk("R5 idx_wr pair", 32'(idx_wr), 1);
    chk("R5 idx_val pair", 32'(idx_val), 32'h0000AB00);
    @(negedge clk);
    run_op(1'b0, 2'b01, 6'd10, 1'b1, 16'h12CA, 16'h0100, 16'h4444, 1'b0, waited);
    chk("R5 idx_val acc early stop", 32'(idx_val), 32'h00001203);
    chk("R11 latency normalize", 32'(waited), 32'd9);
    @(negedge clk);
    // R5 sign already set: zero steps, full count returned
    full_check("R5 sign set", 1'b0, 2'b11, 6'd7, 1'b1, 16'hFFFF, 16'h8000, 16'h1234, 1'b0);
    // R6 tag zero normalize behaves as plain
    full_check("R6 acc plain", 1'b0, 2'b01, 6'd9, 1'b0, 16'hFFFF, 16'h00F3, 16'h0F00, 1'b0);
    full_check("R6 pair plain", 1'b0, 2'b11, 6'd17, 1'b0, 16'hFFFF, 16'h0001, 16'hC003, 1'b0);
    // R10 invalid with count zero is not invalid (R2)
    full_check("R2 zero on bad code", 1'b1, 2'b01, 6'd0, 1'b1, 16'h1111, 16'h5555, 16'hAAAA, 1'b1);
    full_check("R10 invalid", 1'b1, 2'b01, 6'd63, 1'b1, 16'h1111, 16'h5555, 16'hAAAA, 1'b0);
    // R7 boundaries
    full_check("R7 count 15", 1'b1, 2'b00, 6'd15, 1'b0, 16'h0, 16'h8000, 16'h1234, 1'b0);
    full_check("R7 count 16", 1'b1, 2'b00, 6'd16, 1'b0, 16'h0, 16'hFFFF, 16'h1234, 1'b1);
    full_check("R3 count 63", 1'b0, 2'b00, 6'd63, 1'b0, 16'h0, 16'hFFFF, 16'hFFFF, 1'b0);
    full_check("R9 count 32", 1'b1, 2'b11, 6'd32, 1'b0, 16'h0, 16'hDEAD, 16'hBEEF, 1'b0);
    full_check("R8 count 40", 1'b1, 2'b10, 6'd40, 1'b0, 16'h0, 16'h8000, 16'h0000, 1'b1);

    // R12 start while busy is ignored
    ref_op(1'b0, 2'b00, 6'd15, 1'b0, 16'h0, 16'h0003, 16'h7777, 1'b0, ra, re, rc, rw, ri, rinv, steps);
    dir_right = 0; variant = 2'b00; count = 6'd15; tag_nz = 0; idx_in = 0;
    acc_in = 16'h0003; ext_in = 16'h7777; carry_in = 0; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (3) @(negedge clk);
    dir_right = 1; variant = 2'b11; count = 6'd2; acc_in = 16'hFFFF; ext_in = 16'h0; start = 1'b1;
    @(negedge clk); start = 1'b0;
    waited = 0;
    while (!done && waited < 200) begin @(negedge clk); waited++; end
    chk("R12 acc from first op", 32'(acc_out), 32'(ra));
    chk("R12 ext from first op", 32'(ext_out), 32'(re));
    chk("R12 carry from first op", 32'(carry_out), 32'(rc));
    @(negedge clk);
    chk("R12 no second op", 32'(busy), 0);
    // R11 results hold while idle
    repeat (3) @(negedge clk);
    chk("R11 held acc", 32'(acc_out), 32'(ra));

    // random sweep over all variants and counts
    for (int r = 0; r < 400; r++) begin
      full_check("R3-R9 random", 1'($urandom), 2'($urandom), 6'(r % 64), 1'($urandom),
                 16'($urandom), 16'($urandom), 16'($urandom), 1'($urandom));
    end
    // sweeps with small leading-zero operands for normalize depth
    for (int r = 0; r < 64; r++) begin
      full_check("R5 sweep", 1'b0, {1'($urandom), 1'b1}, 6'(r), 1'b1,
                 16'($urandom), 16'($urandom) >> (r % 16), 16'($urandom), 1'($urandom));
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule